// File: doc/BRIEF.md
# Miss Tracking File with Evicted-Upgrade Recovery

This block holds the outstanding misses of a write-back cache, one entry per block address. Each entry records whether its request asked for ownership. The cache allocates an entry when it issues a miss or an upgrade. The replacement logic searches the file by block address before it evicts a victim. When a response returns, the cache hands it over and takes back a fill that frees the entry.

The block also covers a race. The cache may evict a shared line while that line's ownership upgrade is still in flight. If the evicted copy was clean, the entry keeps a private copy of the line. A later upgrade acknowledgement for the missing line then becomes a full exclusive fill that carries that copy. If the evicted copy was dirty, the normal writeback takes the data. The acknowledgement is then dropped, and the entry asks the memory side to send the request again as an exclusive read.

Top module: `mshr_upg_file`

## Requirements
- R1: After reset, `full`, `fillValid`, `reissueValid` and `lookupHit` are all 0.
- R2: `allocIdx` always shows the lowest free entry, and an allocation takes that entry on the clock edge. `full` is 1 exactly when every entry is busy. An allocation attempted while `full` is 1 changes nothing.
- R3: `lookupHit` and `lookupIdx` report the busy entry whose block address (address bits [31:6]) equals that of `lookupAddr`. Offset bits [5:0] are ignored, and at most one entry matches.
- R4: An ordinary response for entry `respIdx` produces a fill on the next cycle. The fill carries `respData`, the entry's block-aligned address, and `fillExcl` equal to the entry's needs-exclusive flag.
- R5: A fill stays valid with unchanged fields until `fillReady`. The entry is freed on the cycle the fill is accepted, so afterwards a lookup of its address misses and `full` drops.
- R6: A clean eviction (`evictDirty`=0) of a busy, exclusive-request entry saves `evictData`. A later upgrade response with `respLineGone`=1 then fills with the saved line and `fillExcl`=1, and `respData` is ignored. A victim that matches an entry is never writable.
- R7: A dirty eviction of a busy entry, followed by an upgrade response with `respLineGone`=1, gives no fill. Instead `reissueValid` rises with that entry's index and block address and stays high until `reissueGrant`. The entry stays busy.
- R8: A response that arrives after a reissue is an ordinary exclusive-read response. It fills with `respData` and frees the entry.
- R9: An eviction whose address matches no busy entry has no effect. Later ordinary fills still carry `respData`.
- R10: An upgrade response with `respLineGone`=0 is an ordinary response, filling with `respData` and `fillExcl`=1.
- R11: `respReady` is 0 while a fill waits. Every accepted response yields either a fill or a reissue request on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate an entry this cycle |
| allocAddr | input | 32 | Address of the new miss |
| allocExcl | input | 1 | New request needs ownership |
| allocIdx | output | 2 | Entry an allocation would take |
| full | output | 1 | No free entry |
| lookupAddr | input | 32 | Address searched by replacement logic |
| lookupHit | output | 1 | A busy entry matches lookupAddr |
| lookupIdx | output | 2 | Matching entry |
| evictValid | input | 1 | A valid victim is being evicted |
| evictAddr | input | 32 | Victim block address |
| evictDirty | input | 1 | Victim is dirty |
| evictWritable | input | 1 | Victim is held with write permission |
| evictData | input | 512 | Victim line contents |
| respValid | input | 1 | Response presented |
| respReady | output | 1 | Response accepted this cycle |
| respIdx | input | 2 | Entry the response belongs to |
| respUpgrade | input | 1 | Response is an upgrade acknowledgement |
| respLineGone | input | 1 | Addressed line no longer in the cache |
| respData | input | 512 | Response line data |
| fillValid | output | 1 | Fill waiting for the cache |
| fillReady | input | 1 | Cache takes the fill |
| fillIdx | output | 2 | Entry being filled |
| fillAddr | output | 32 | Block-aligned fill address |
| fillExcl | output | 1 | Fill grants ownership |
| fillData | output | 512 | Fill line data |
| reissueValid | output | 1 | Entry asks to resend as exclusive read |
| reissueGrant | input | 1 | Memory side accepts the reissue |
| reissueIdx | output | 2 | Entry being reissued |
| reissueAddr | output | 32 | Block-aligned reissue address |

## Verification
Wrong recovery state shows up at the fill port one cycle after the upgrade response. A lost saved line shows as fill data equal to `respData` rather than the evicted line. A wrong dirty flag shows as a fill where a reissue was due, or the other way round. Bad valid bits show one cycle after a fill is accepted: a stale entry keeps `lookupHit` or `full` set, and a wrong `allocIdx` shows at the next allocation. The bench rotates every response kind across every entry over several rounds, so a fault tied to one index or one kind is exposed.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // Widest entry index the strobe struct can carry (up to 16 entries).
  localparam int unsigned IDX_W_MAX = 4;

  // Strobes the control sends to the datapath each cycle.
  typedef struct packed {
    logic                 saveLine;  // capture evicted line into a private buffer
    logic [IDX_W_MAX-1:0] saveIdx;
    logic                 loadFill;  // load the fill data register
    logic                 useSaved;  // fill data comes from the private buffer
    logic [IDX_W_MAX-1:0] fillIdx;
  } mshrStrobe_t;
endpackage

// File: rtl/mshr_upg_ctrl.sv
module mshr_upg_ctrl
  import mshr_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned OFFS_W      = 6,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
  localparam int unsigned BLK_W      = ADDR_W - OFFS_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   allocValid,
  input  logic [ADDR_W-1:0]      allocAddr,
  input  logic                   allocExcl,
  output logic [IDX_W-1:0]       allocIdx,
  output logic                   full,
  input  logic [ADDR_W-1:0]      lookupAddr,
  output logic [NUM_ENTRIES-1:0] lookupMatch,
  input  logic                   evictValid,
  input  logic [ADDR_W-1:0]      evictAddr,
  input  logic                   evictDirty,
  input  logic                   evictWritable,
  input  logic                   respValid,
  output logic                   respReady,
  input  logic [IDX_W-1:0]       respIdx,
  input  logic                   respUpgrade,
  input  logic                   respLineGone,
  output logic                   fillValid,
  input  logic                   fillReady,
  output logic [IDX_W-1:0]       fillIdx,
  output logic [ADDR_W-1:0]      fillAddr,
  output logic                   fillExcl,
  output logic                   reissueValid,
  input  logic                   reissueGrant,
  output logic [IDX_W-1:0]       reissueIdx,
  output logic [ADDR_W-1:0]      reissueAddr,
  output mshrStrobe_t            stb
);
  logic [NUM_ENTRIES-1:0] busyQ, exclQ, replPendQ, replDirtyQ, bufHeldQ, reissQ;
  logic [BLK_W-1:0]       blkQ [NUM_ENTRIES];
  logic                   fillVldQ, fillExclQ;
  logic [IDX_W-1:0]       fillIdxQ;

  logic [NUM_ENTRIES-1:0] evMatch;
  logic                   evHit, special, respFire, allocFire;
  logic [IDX_W-1:0]       evIdx;

  // Address comparators, one pair per entry.
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign lookupMatch[e] = busyQ[e] && (blkQ[e] == lookupAddr[ADDR_W-1:OFFS_W]);
    assign evMatch[e]     = busyQ[e] && (blkQ[e] == evictAddr[ADDR_W-1:OFFS_W]);
  end

  // Lowest-index selectors.
  always_comb begin
    allocIdx   = '0;
    evIdx      = '0;
    reissueIdx = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (!busyQ[e])  allocIdx   = IDX_W'(e);
      if (evMatch[e]) evIdx      = IDX_W'(e);
      if (reissQ[e])  reissueIdx = IDX_W'(e);
    end
  end

  assign full         = &busyQ;
  assign evHit        = |evMatch;
  assign respReady    = !fillVldQ;
  assign respFire     = respValid && respReady;
  assign allocFire    = allocValid && !full;
  assign special      = respUpgrade && respLineGone;
  assign reissueValid = |reissQ;
  assign reissueAddr  = {blkQ[reissueIdx], {OFFS_W{1'b0}}};

  assign fillValid = fillVldQ;
  assign fillIdx   = fillIdxQ;
  assign fillExcl  = fillExclQ;
  assign fillAddr  = {blkQ[fillIdxQ], {OFFS_W{1'b0}}};

  always_comb begin
    stb.saveLine = evictValid && evHit && !evictWritable && !evictDirty;
    stb.saveIdx  = IDX_W_MAX'(evIdx);
    stb.loadFill = respFire && !(special && replDirtyQ[respIdx]);
    stb.useSaved = special && bufHeldQ[respIdx];
    stb.fillIdx  = IDX_W_MAX'(respIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= '0;
      exclQ      <= '0;
      replPendQ  <= '0;
      replDirtyQ <= '0;
      bufHeldQ   <= '0;
      reissQ     <= '0;
      fillVldQ   <= 1'b0;
      fillExclQ  <= 1'b0;
      fillIdxQ   <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) blkQ[e] <= '0;
    end else begin
      if (fillVldQ && fillReady) begin
        busyQ[fillIdxQ] <= 1'b0;
        fillVldQ        <= 1'b0;
      end
      if (reissueValid && reissueGrant) reissQ[reissueIdx] <= 1'b0;
      if (allocFire) begin
        busyQ[allocIdx]      <= 1'b1;
        blkQ[allocIdx]       <= allocAddr[ADDR_W-1:OFFS_W];
        exclQ[allocIdx]      <= allocExcl;
        replPendQ[allocIdx]  <= 1'b0;
        replDirtyQ[allocIdx] <= 1'b0;
        bufHeldQ[allocIdx]   <= 1'b0;
        reissQ[allocIdx]     <= 1'b0;
      end
      if (evictValid && evHit && !evictWritable) begin
        replPendQ[evIdx]  <= 1'b1;
        replDirtyQ[evIdx] <= evictDirty;
        bufHeldQ[evIdx]   <= !evictDirty;
      end
      if (respFire) begin
        if (special) begin
          replPendQ[respIdx] <= 1'b0;
          bufHeldQ[respIdx]  <= 1'b0;
        end
        if (special && replDirtyQ[respIdx]) begin
          reissQ[respIdx]     <= 1'b1;
          replDirtyQ[respIdx] <= 1'b0;
        end else begin
          fillVldQ  <= 1'b1;
          fillIdxQ  <= respIdx;
          fillExclQ <= special || exclQ[respIdx];
        end
      end
    end
  end
endmodule

// File: rtl/mshr_upg_dpath.sv
module mshr_upg_dpath
  import mshr_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned LINE_W      = 512,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  mshrStrobe_t       stb,
  input  logic [LINE_W-1:0] evictData,
  input  logic [LINE_W-1:0] respData,
  output logic [LINE_W-1:0] fillData
);
  logic [NUM_ENTRIES-1:0][LINE_W-1:0] bufOut;
  logic [LINE_W-1:0]                  fillDataQ;

  // One private line buffer per entry.
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_buf
    logic [LINE_W-1:0] held;
    always_ff @(posedge clk) begin
      if (stb.saveLine && (stb.saveIdx[IDX_W-1:0] == IDX_W'(e))) held <= evictData;
    end
    assign bufOut[e] = held;
  end

  always_ff @(posedge clk) begin
    if (stb.loadFill)
      fillDataQ <= stb.useSaved ? bufOut[stb.fillIdx[IDX_W-1:0]] : respData;
  end

  assign fillData = fillDataQ;
endmodule

// File: rtl/mshr_upg_file.sv
module mshr_upg_file
  import mshr_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LINE_BYTES  = 64,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
  localparam int unsigned OFFS_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              allocExcl,
  output logic [IDX_W-1:0]  allocIdx,
  output logic              full,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupHit,
  output logic [IDX_W-1:0]  lookupIdx,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic              evictDirty,
  input  logic              evictWritable,
  input  logic [LINE_W-1:0] evictData,
  input  logic              respValid,
  output logic              respReady,
  input  logic [IDX_W-1:0]  respIdx,
  input  logic              respUpgrade,
  input  logic              respLineGone,
  input  logic [LINE_W-1:0] respData,
  output logic              fillValid,
  input  logic              fillReady,
  output logic [IDX_W-1:0]  fillIdx,
  output logic [ADDR_W-1:0] fillAddr,
  output logic              fillExcl,
  output logic [LINE_W-1:0] fillData,
  output logic              reissueValid,
  input  logic              reissueGrant,
  output logic [IDX_W-1:0]  reissueIdx,
  output logic [ADDR_W-1:0] reissueAddr
);
  mshrStrobe_t            stb;
  logic [NUM_ENTRIES-1:0] lookupMatch;

  mshr_upg_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_ctrl (
    .clk, .rstN, .allocValid, .allocAddr, .allocExcl, .allocIdx, .full,
    .lookupAddr, .lookupMatch, .evictValid, .evictAddr, .evictDirty, .evictWritable,
    .respValid, .respReady, .respIdx, .respUpgrade, .respLineGone,
    .fillValid, .fillReady, .fillIdx, .fillAddr, .fillExcl,
    .reissueValid, .reissueGrant, .reissueIdx, .reissueAddr, .stb
  );

  mshr_upg_dpath #(.NUM_ENTRIES(NUM_ENTRIES), .LINE_W(LINE_W)) u_dpath (
    .clk, .stb, .evictData, .respData, .fillData
  );

  // Encode the single match for the replacement logic.
  always_comb begin
    lookupIdx = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) if (lookupMatch[e]) lookupIdx = IDX_W'(e);
  end
  assign lookupHit = |lookupMatch;
endmodule

// File: rtl/mshr_upg_chk.sv
module mshr_upg_chk #(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned OFFS_W      = 6,
  parameter int unsigned LINE_W      = 512
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_ENTRIES-1:0] lookupMatch,
  input logic                   lookupHit,
  input logic [ADDR_W-1:0]      lookupAddr,
  input logic                   evictValid,
  input logic [ADDR_W-1:0]      evictAddr,
  input logic                   evictWritable,
  input logic                   respValid,
  input logic                   respReady,
  input logic                   fillValid,
  input logic                   fillReady,
  input logic [$clog2(NUM_ENTRIES)-1:0] fillIdx,
  input logic [LINE_W-1:0]      fillData,
  input logic                   reissueValid,
  input logic                   reissueGrant
);
  // R3
  lookup_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookupMatch));

  // R5
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && !fillReady |=> fillValid && $stable(fillIdx) && $stable(fillData));

  // R6
  evict_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    evictValid && lookupHit &&
    (lookupAddr[ADDR_W-1:OFFS_W] == evictAddr[ADDR_W-1:OFFS_W]) |-> !evictWritable);

  // R7
  reissue_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reissueValid && !reissueGrant |=> reissueValid);

  // R11
  resp_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respReady |=> fillValid || reissueValid);
endmodule

bind mshr_upg_file mshr_upg_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .lookupMatch(lookupMatch), .lookupHit(lookupHit),
  .lookupAddr(lookupAddr), .evictValid(evictValid), .evictAddr(evictAddr),
  .evictWritable(evictWritable), .respValid(respValid), .respReady(respReady),
  .fillValid(fillValid), .fillReady(fillReady), .fillIdx(fillIdx), .fillData(fillData),
  .reissueValid(reissueValid), .reissueGrant(reissueGrant)
);

// File: tb/mshr_upg_file_test.sv
module mshr_upg_file_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int LW = 512;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, allocExcl = 0, evictValid = 0, evictDirty = 0, evictWritable = 0;
  logic respValid = 0, respUpgrade = 0, respLineGone = 0, fillReady = 0, reissueGrant = 0;
  logic [31:0] allocAddr = '0, lookupAddr = '0, evictAddr = '0;
  logic [1:0] respIdx = '0;
  logic [LW-1:0] evictData = '0, respData = '0;
  logic [1:0] allocIdx, lookupIdx, fillIdx, reissueIdx;
  logic full, lookupHit, respReady, fillValid, fillExcl, reissueValid;
  logic [31:0] fillAddr, reissueAddr;
  logic [LW-1:0] fillData;

  int total = 0, bad = 0, cycles = 0;
  localparam logic [31:0] UNREL = 32'hFFFF_0000;

  mshr_upg_file uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] addrOf(int r, int i);
    return 32'h1000_0000 + (r << 12) + (i << 6) + 5;
  endfunction

  task automatic doEvict(input logic [31:0] a, input bit dirty, input logic [LW-1:0] d);
    evictValid = 1; evictAddr = a; evictDirty = dirty; evictData = d; lookupAddr = a;
    tick();
    evictValid = 0;
  endtask

  task automatic doResp(input int i, input bit upg, input bit gone, input logic [LW-1:0] d, input string req);
    respValid = 1; respIdx = 2'(i); respUpgrade = upg; respLineGone = gone; respData = d;
    #1 chk(respReady == 1'b1, req, 64'(respReady), 64'd1);
    tick();
    respValid = 0; respUpgrade = 0; respLineGone = 0;
  endtask

  task automatic expectFill(input int i, input logic [31:0] a, input bit ex, input logic [LW-1:0] d, input string req);
    chk(fillValid === 1'b1, req, 64'(fillValid), 64'd1);
    chk(fillIdx == 2'(i) && fillAddr == {a[31:6], 6'd0} && fillExcl == ex, req,
        {30'd0, fillIdx, fillAddr}, {30'd0, 2'(i), a[31:6], 6'd0});
    chk(fillData == d, req, fillData[63:0], d[63:0]);
    tick(); // held with fillReady low
    // R5 R11
    chk(fillValid && fillIdx == 2'(i) && fillData == d && !respReady, "R5",
        {62'd0, fillValid, respReady}, 64'd2);
    fillReady = 1;
    tick();
    fillReady = 0;
    lookupAddr = a; #1;
    // R5
    chk(!fillValid && !lookupHit && !full, "R5", {61'd0, fillValid, lookupHit, full}, 64'd0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    lookupAddr = addrOf(0, 0); #1;
    // R1
    chk(!full && !fillValid && !reissueValid && !lookupHit, "R1",
        {60'd0, full, fillValid, reissueValid, lookupHit}, 64'd0);

    for (int r = 0; r < 4; r++) begin
      // R2: allocation order
      for (int i = 0; i < N; i++) begin
        allocValid = 1; allocAddr = addrOf(r, i);
        allocExcl = ((i + r) % 4 != 0) || r[0];
        #1 chk(allocIdx == 2'(i) && !full, "R2", 64'(allocIdx), 64'(i));
        tick();
        allocValid = 0;
      end
      #1 chk(full, "R2", 64'(full), 64'd1);
      allocValid = 1; allocAddr = UNREL; allocExcl = 0;
      tick();
      allocValid = 0; lookupAddr = UNREL; #1;
      chk(!lookupHit && full, "R2", {62'd0, lookupHit, full}, 64'd1);
      // R3: lookup with another offset
      for (int i = 0; i < N; i++) begin
        lookupAddr = addrOf(r, i) + 32'd50; #1;
        chk(lookupHit && lookupIdx == 2'(i), "R3", {62'd0, lookupIdx}, 64'(i));
      end
      // R9: eviction of an untracked line
      doEvict(UNREL, 1'b0, {16{32'hDEAD_BEEF}});

      for (int i = 0; i < N; i++) begin
        automatic int kind = (i + r) % 4;
        automatic logic [31:0] a = addrOf(r, i);
        automatic logic [LW-1:0] eD = {16{32'hE000_0000 | (r << 8) | i}};
        automatic logic [LW-1:0] rD = {16{32'h5000_0000 | (r << 8) | i}};
        automatic logic [LW-1:0] jD = {16{32'h0BAD_0000 | i}};
        case (kind)
          0: begin
            doResp(i, 0, 0, rD, "R4");
            expectFill(i, a, r[0], rD, "R4/R9");
          end
          1: begin
            doEvict(a + 32'd7, 1'b0, eD);
            doResp(i, 1, 1, jD, "R6");
            expectFill(i, a, 1'b1, eD, "R6");
          end
          2: begin
            doEvict(a + 32'd9, 1'b1, eD);
            doResp(i, 1, 1, jD, "R7");
            chk(!fillValid && reissueValid && reissueIdx == 2'(i) &&
                reissueAddr == {a[31:6], 6'd0}, "R7", {30'd0, reissueIdx, reissueAddr},
                {30'd0, 2'(i), a[31:6], 6'd0});
            tick();
            lookupAddr = a; #1;
            chk(reissueValid && lookupHit && lookupIdx == 2'(i) && !fillValid, "R7",
                {61'd0, reissueValid, lookupHit, fillValid}, 64'd6);
            reissueGrant = 1;
            tick();
            reissueGrant = 0; #1;
            chk(!reissueValid && lookupHit, "R7", {62'd0, reissueValid, lookupHit}, 64'd1);
            doResp(i, 0, 1, rD, "R8");
            expectFill(i, a, 1'b1, rD, "R8");
          end
          default: begin
            doResp(i, 1, 0, rD, "R10");
            expectFill(i, a, 1'b1, rD, "R10");
          end
        endcase
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule